// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block sits in front of a 16 KB on-chip scratchpad built from 16 single-port banks, each one 32-bit word wide. Successive 32-bit words go to successive banks. A group of 16 lanes presents one request. Each lane carries an enable bit and a byte address. All lanes share one read/write direction, and each lane has its own store data.

Each bank can serve one word per cycle. The block therefore looks at which lanes compete for the same bank. It splits the request into passes. In every pass, each bank serves the lowest-numbered lane still waiting on it. In that same pass it also serves every other waiting lane that wants the very same word. Served lanes drop out, and passes repeat until no lane is waiting.

When the request ends, the block reports per-lane read data and the number of passes it used. That pass count equals the largest number of distinct words any single bank was asked for, so it can feed a performance counter directly.

Top module: `spad_conflict_serializer`

## Requirements
- R1: Lane byte addresses are 14 bits. Bits [5:2] select the bank, bits [13:6] select the row within the bank, and bits [1:0] are ignored. Addresses that differ only in bits [1:0] name the same word.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance through the last cycle before `rsp_done`, and it is high again in the `rsp_done` cycle. A request presented while `req_ready` is low is neither taken nor allowed to touch storage.
- R3: `rsp_passes` equals the largest number of distinct words requested by active lanes from any one bank. Lanes that request different words of the same bank are served in separate passes.
- R4: Active lanes that address the same word are served together in one pass, and all of them receive that word.
- R5: `rsp_done` is a single-cycle pulse. It is first high P+1 clock edges after the accepting edge, where P is the reported pass count. `rsp_rdata` and `rsp_passes` are valid while it is high.
- R6: After a read, each active lane's slice of `rsp_rdata` (lane i at bits [32i+31:32i]) holds the stored word at its address. Inactive lanes keep their previous value.
- R7: A write stores each active lane's `req_wdata` slice at its word. When several active lanes write the same word, the highest-numbered lane's data remains.
- R8: A request with no active lane reports zero passes, pulses `rsp_done` one edge after acceptance, and changes no stored word.
- R9: Strides of 2, 4 and 8 words across the lanes take 2, 4 and 8 passes. The same strides with one extra word inserted after every 16 take 1 pass.
- R10: After reset, `req_ready` is 1, `rsp_done` is 0, `rsp_passes` is 0 and `rsp_rdata` is all zero.
- R11: A write request leaves `rsp_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = store, 0 = load, for all lanes |
| req_active | input | 16 | Per-lane enable |
| req_addr | input | 224 | Per-lane byte address, lane i at bits [14i+13:14i] |
| req_wdata | input | 512 | Per-lane store data, lane i at bits [32i+31:32i] |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_passes | output | 5 | Number of passes the request used |
| rsp_rdata | output | 512 | Per-lane load data, lane i at bits [32i+31:32i] |

## Verification
A request with P passes must show `rsp_done` exactly P+1 edges after the accepting edge, and an empty request must show it after one edge. The bench counts edges from acceptance, samples a moment after each edge, and compares the count at the first high `rsp_done` with the pass count it computes from the addresses. The read data and the pass count are compared in that same done cycle, against a word-level model of the storage. The bench also watches `req_ready` on every edge between acceptance and completion, and a request held on the inputs during that window must leave storage untouched.

// File: rtl/spad_pkg.sv
package spad_pkg;

  typedef enum logic [1:0] {
    SP_IDLE  = 2'd0,
    SP_RUN   = 2'd1,
    SP_DRAIN = 2'd2
  } spad_state_e;

endpackage

// File: rtl/spad_bank_ram.sv
module spad_bank_ram #(
  parameter int ROWS   = 256,
  parameter int DATA_W = 32,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ROW_W-1:0]  addr,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        mem[addr] <= wd;
      end
      q <= mem[addr];
    end
  end

endmodule

// File: rtl/spad_bank_pick.sv
module spad_bank_pick #(
  parameter int LANES   = 16,
  parameter int BANK_W  = 4,
  parameter int ROW_W   = 8,
  parameter int DATA_W  = 32,
  parameter int BANK_ID = 0
) (
  input  logic [LANES-1:0]        pending,
  input  logic [LANES*BANK_W-1:0] lane_bank,
  input  logic [LANES*ROW_W-1:0]  lane_row,
  input  logic [LANES*DATA_W-1:0] lane_wdata,
  output logic                    hit,
  output logic [ROW_W-1:0]        row_sel,
  output logic [LANES-1:0]        served,
  output logic [DATA_W-1:0]       wdata_sel
);

  localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(BANK_ID);

  logic [LANES-1:0] wants;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      wants[l] = pending[l] && (lane_bank[l*BANK_W +: BANK_W] == MY_BANK);
    end
  end

  // lowest waiting lane picks the row of this pass
  always_comb begin
    hit     = 1'b0;
    row_sel = '0;
    for (int l = LANES - 1; l >= 0; l--) begin
      if (wants[l]) begin
        hit     = 1'b1;
        row_sel = lane_row[l*ROW_W +: ROW_W];
      end
    end
  end

  // every lane on the picked row rides along; highest lane's data is kept
  always_comb begin
    wdata_sel = '0;
    for (int l = 0; l < LANES; l++) begin
      served[l] = wants[l] && (lane_row[l*ROW_W +: ROW_W] == row_sel);
      if (served[l]) begin
        wdata_sel = lane_wdata[l*DATA_W +: DATA_W];
      end
    end
  end

endmodule

// File: rtl/spad_conflict_serializer.sv
module spad_conflict_serializer
  import spad_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int BANKS  = 16,
  parameter int ROWS   = 256,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(DATA_W / 8) + $clog2(BANKS) + $clog2(ROWS),
  localparam int PASS_W = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [LANES-1:0]        req_active,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  input  logic [LANES*DATA_W-1:0] req_wdata,
  output logic                    rsp_done,
  output logic [PASS_W-1:0]       rsp_passes,
  output logic [LANES*DATA_W-1:0] rsp_rdata
);

  localparam int BOFF   = $clog2(DATA_W / 8);
  localparam int BANK_W = $clog2(BANKS);
  localparam int ROW_W  = $clog2(ROWS);

  spad_state_e              state_q;
  logic [LANES-1:0]         pending_q;
  logic [LANES-1:0]         served_q;
  logic                     wr_q;
  logic [PASS_W-1:0]        passes_q;
  logic                     done_q;
  logic [BANK_W-1:0]        bank_q [LANES];
  logic [ROW_W-1:0]         row_q  [LANES];
  logic [LANES*DATA_W-1:0]  wdata_q;
  logic [DATA_W-1:0]        rdata_q [LANES];

  logic [LANES*BANK_W-1:0]  bank_flat;
  logic [LANES*ROW_W-1:0]   row_flat;
  logic [BANKS-1:0]         bank_hit;
  logic [ROW_W-1:0]         bank_row [BANKS];
  logic [LANES-1:0]         bank_served [BANKS];
  logic [DATA_W-1:0]        bank_wd [BANKS];
  logic [DATA_W-1:0]        bank_rd [BANKS];
  logic [LANES-1:0]         served_all;
  logic [LANES-1:0]         left_after;
  logic                     unused_byte_offset;

  always_comb begin
    unused_byte_offset = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      unused_byte_offset = unused_byte_offset ^ (^req_addr[l*ADDR_W +: BOFF]);
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      bank_flat[l*BANK_W +: BANK_W] = bank_q[l];
      row_flat[l*ROW_W +: ROW_W]    = row_q[l];
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    spad_bank_pick #(
      .LANES  (LANES),
      .BANK_W (BANK_W),
      .ROW_W  (ROW_W),
      .DATA_W (DATA_W),
      .BANK_ID(b)
    ) i_pick (
      .pending   (pending_q),
      .lane_bank (bank_flat),
      .lane_row  (row_flat),
      .lane_wdata(wdata_q),
      .hit       (bank_hit[b]),
      .row_sel   (bank_row[b]),
      .served    (bank_served[b]),
      .wdata_sel (bank_wd[b])
    );

    spad_bank_ram #(
      .ROWS  (ROWS),
      .DATA_W(DATA_W)
    ) i_ram (
      .clk (clk),
      .en  (bank_hit[b]),
      .we  (bank_hit[b] && wr_q),
      .addr(bank_row[b]),
      .wd  (bank_wd[b]),
      .q   (bank_rd[b])
    );
  end

  always_comb begin
    served_all = '0;
    for (int b = 0; b < BANKS; b++) begin
      served_all = served_all | bank_served[b];
    end
    left_after = pending_q & ~served_all;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SP_IDLE;
      pending_q <= '0;
      served_q  <= '0;
      wr_q      <= 1'b0;
      passes_q  <= '0;
      done_q    <= 1'b0;
      wdata_q   <= '0;
      for (int l = 0; l < LANES; l++) begin
        bank_q[l] <= '0;
        row_q[l]  <= '0;
      end
    end else begin
      done_q   <= 1'b0;
      served_q <= served_all;
      case (state_q)
        SP_IDLE: begin
          if (req_valid) begin
            pending_q <= req_active;
            wr_q      <= req_write;
            wdata_q   <= req_wdata;
            passes_q  <= '0;
            for (int l = 0; l < LANES; l++) begin
              bank_q[l] <= req_addr[l*ADDR_W + BOFF +: BANK_W];
              row_q[l]  <= req_addr[l*ADDR_W + BOFF + BANK_W +: ROW_W];
            end
            state_q <= (|req_active) ? SP_RUN : SP_DRAIN;
          end
        end
        SP_RUN: begin
          pending_q <= left_after;
          passes_q  <= passes_q + PASS_W'(1);
          if (left_after == '0) begin
            state_q <= SP_DRAIN;
          end
        end
        SP_DRAIN: begin
          done_q  <= 1'b1;
          state_q <= SP_IDLE;
        end
        default: state_q <= SP_IDLE;
      endcase
    end
  end

  // bank outputs arrive one edge after the pass that addressed them
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l < LANES; l++) begin
        rdata_q[l] <= '0;
      end
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (served_q[l] && !wr_q) begin
          rdata_q[l] <= bank_rd[bank_q[l]];
        end
      end
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      rsp_rdata[l*DATA_W +: DATA_W] = rdata_q[l];
    end
  end

  assign req_ready  = (state_q == SP_IDLE);
  assign rsp_done   = done_q;
  assign rsp_passes = passes_q;

endmodule

// File: rtl/spad_serializer_chk.sv
module spad_serializer_chk #(
  parameter int LANES  = 16,
  parameter int DATA_W = 32,
  parameter int PASS_W = 5
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic                    req_write,
  input logic [LANES-1:0]        req_active,
  input logic                    rsp_done,
  input logic [PASS_W-1:0]       rsp_passes,
  input logic [LANES*DATA_W-1:0] rsp_rdata
);

  logic       take;
  logic [7:0] since_q;
  logic [7:0] nact_q;
  logic       wr_l;

  assign take = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_q <= '0;
      nact_q  <= '0;
      wr_l    <= 1'b0;
    end else if (take) begin
      since_q <= 8'd0;
      nact_q  <= 8'($countones(req_active));
      wr_l    <= req_write;
    end else if (since_q != 8'hFF) begin
      since_q <= since_q + 8'd1;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) rsp_done |=> !rsp_done); // R5
  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst) take |=> !req_ready); // R2
  AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (rst) rsp_done |-> req_ready); // R2
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst) rsp_done |-> (int'(since_q) == int'(rsp_passes) + 1)); // R5
  AST_PASS_LIMIT: assert property (@(posedge clk) disable iff (rst) rsp_done |-> (int'(rsp_passes) <= int'(nact_q))); // R3
  AST_NONEMPTY_PASS: assert property (@(posedge clk) disable iff (rst) (rsp_done && nact_q != 8'd0) |-> (rsp_passes != '0)); // R3
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst) (rsp_done && nact_q == 8'd0) |-> (rsp_passes == '0)); // R8
  AST_WRITE_KEEPS_RDATA: assert property (@(posedge clk) disable iff (rst) (!req_ready && wr_l) |=> $stable(rsp_rdata)); // R11

endmodule

bind spad_conflict_serializer spad_serializer_chk #(
  .LANES (LANES),
  .DATA_W(DATA_W),
  .PASS_W(PASS_W)
) i_chk (.*);

// File: tb/test_spad_conflict_serializer.sv
`timescale 1ns/100ps
module test_spad_conflict_serializer;

  localparam int LANES = 16;
  localparam int DW    = 32;
  localparam int AW    = 14;
  localparam int PW    = 5;
  localparam int WORDS = 4096;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 req_valid = 1'b0;
  logic                 req_ready;
  logic                 req_write = 1'b0;
  logic [LANES-1:0]     req_active = '0;
  logic [LANES*AW-1:0]  req_addr = '0;
  logic [LANES*DW-1:0]  req_wdata = '0;
  logic                 rsp_done;
  logic [PW-1:0]        rsp_passes;
  logic [LANES*DW-1:0]  rsp_rdata;

  always #2.5 clk = ~clk;

  spad_conflict_serializer i_spad_conflict_serializer (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_active(req_active),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_done  (rsp_done),
    .rsp_passes(rsp_passes),
    .rsp_rdata (rsp_rdata)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  logic [DW-1:0]    model  [WORDS];
  logic [DW-1:0]    exp_rd [LANES];
  logic [AW-1:0]    la     [LANES];
  logic [DW-1:0]    lw     [LANES];
  logic [LANES-1:0] act;
  logic [31:0]      seed = 32'h1234_5678;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog: run did not finish actual=%0d expected<%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] actual, input logic [63:0] expected);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, actual, expected);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  function automatic int word_of(input logic [AW-1:0] a);
    return int'(a[AW-1:2]);
  endfunction

  // largest count of distinct words asked from one bank
  function automatic int calc_passes();
    int best = 0;
    for (int b = 0; b < 16; b++) begin
      int n = 0;
      for (int l = 0; l < LANES; l++) begin
        if (act[l] && la[l][5:2] == 4'(b)) begin
          bit seen = 1'b0;
          for (int j = 0; j < l; j++) begin
            if (act[j] && word_of(la[j]) == word_of(la[l])) seen = 1'b1;
          end
          if (!seen) n++;
        end
      end
      if (n > best) best = n;
    end
    return best;
  endfunction

  task automatic drive(input bit wr);
    req_write  = wr;
    req_active = act;
    for (int l = 0; l < LANES; l++) begin
      req_addr[l*AW +: AW]  = la[l];
      req_wdata[l*DW +: DW] = lw[l];
    end
  endtask

  task automatic run(input bit wr, input int exp_p, input string preq);
    int  lat;
    bit  busy_ok;
    bit  rd_ok;
    int  bad;
    while (!req_ready) begin
      @(posedge clk); #1;
    end
    drive(wr);
    req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    lat = 0;
    busy_ok = 1'b1;
    while (!rsp_done && lat < 64) begin
      if (req_ready) busy_ok = 1'b0;
      @(posedge clk); #1;
      lat++;
    end
    if (wr) begin
      for (int l = 0; l < LANES; l++) begin
        if (act[l]) model[word_of(la[l])] = lw[l];
      end
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (act[l]) exp_rd[l] = model[word_of(la[l])];
      end
    end
    check(busy_ok, "R2", "ready stayed low while busy", 64'(busy_ok), 64'd1);
    check(lat == exp_p + 1, "R5", "done latency", 64'(lat), 64'(exp_p + 1));
    check(int'(rsp_passes) == exp_p, preq, "pass count", 64'(rsp_passes), 64'(exp_p));
    rd_ok = 1'b1;
    bad = 0;
    for (int l = LANES - 1; l >= 0; l--) begin
      if (rsp_rdata[l*DW +: DW] !== exp_rd[l]) begin
        rd_ok = 1'b0;
        bad = l;
      end
    end
    check(rd_ok, wr ? "R11" : "R6", $sformatf("rdata lane %0d", bad),
          64'(rsp_rdata[bad*DW +: DW]), 64'(exp_rd[bad]));
  endtask

  task automatic run_auto(input bit wr, input string preq);
    run(wr, calc_passes(), preq);
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) model[i] = '0;
    for (int l = 0; l < LANES; l++) exp_rd[l] = '0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    #1;
    // R10 reset state
    check(req_ready == 1'b1, "R10", "ready after reset", 64'(req_ready), 64'd1);
    check(rsp_done == 1'b0, "R10", "done after reset", 64'(rsp_done), 64'd0);
    check(rsp_passes == '0, "R10", "passes after reset", 64'(rsp_passes), 64'd0);
    check(rsp_rdata == '0, "R10", "rdata after reset", 64'(rsp_rdata[63:0]), 64'd0);

    // R7 R1: fill every word with consecutive-lane writes, one pass each
    act = '1;
    for (int r = 0; r < WORDS / LANES; r++) begin
      for (int l = 0; l < LANES; l++) begin
        la[l] = AW'((r * LANES + l) * 4);
        lw[l] = {16'(r) ^ 16'hA5C3, 16'(l) ^ 16'h3C00};
      end
      run(1'b1, 1, "R1");
    end
    // R6 R1: read back every word
    for (int r = 0; r < WORDS / LANES; r++) begin
      for (int l = 0; l < LANES; l++) la[l] = AW'((r * LANES + l) * 4 + (l % 4));
      run(1'b0, 1, "R1");
    end

    // R9: strides with and without one pad word per 16
    for (int k = 0; k < 5; k++) begin
      int s = 1 << k;
      for (int l = 0; l < LANES; l++) la[l] = AW'((l * s) * 4);
      run(1'b0, s, "R9");
      for (int l = 0; l < LANES; l++) la[l] = AW'((l * s + (l * s) / 16) * 4);
      run(1'b0, 1, "R9");
    end

    // R4: all lanes on one word, differing byte offsets
    for (int l = 0; l < LANES; l++) la[l] = AW'(14'h0100 + (l % 4));
    run(1'b0, 1, "R4");
    // R4 R3: two words of one bank shared by even and odd lanes
    for (int l = 0; l < LANES; l++) la[l] = (l % 2 == 0) ? AW'(14'h0104) : AW'(14'h0144);
    run(1'b0, 2, "R4");
    // R3: three lanes, three words, one bank
    act = 16'h0007;
    la[0] = AW'(14'h0008); la[1] = AW'(14'h0048); la[2] = AW'(14'h0088);
    run(1'b0, 3, "R3");
    // R3: three lanes, three banks
    la[1] = AW'(14'h004C); la[2] = AW'(14'h0090);
    run(1'b0, 1, "R3");

    // R7: same-word write, highest lane wins
    act = 16'h0208;
    for (int l = 0; l < LANES; l++) begin
      la[l] = AW'(14'h0200);
      lw[l] = 32'hBEEF_0000 | 32'(l);
    end
    run(1'b1, 1, "R7");
    act = 16'h0001;
    run(1'b0, 1, "R7");
    check(rsp_rdata[DW-1:0] == 32'hBEEF_0009, "R7", "same-word winner",
          64'(rsp_rdata[DW-1:0]), 64'h0BEEF_0009);

    // R8: empty write request
    act = '0;
    for (int l = 0; l < LANES; l++) begin
      la[l] = AW'(14'h0300 + l * 4);
      lw[l] = 32'hDEAD_0000;
    end
    run(1'b1, 0, "R8");
    act = '1;
    run(1'b0, 1, "R8");
    check(rsp_rdata[DW-1:0] != 32'hDEAD_0000, "R8", "empty write left storage",
          64'(rsp_rdata[DW-1:0]), 64'(model[word_of(14'h0300)]));

    // R6: inactive lanes keep old data
    act = 16'h00FF;
    for (int l = 0; l < LANES; l++) la[l] = AW'(14'h0400 + l * 4);
    run(1'b0, 1, "R6");
    check(rsp_rdata[15*DW +: DW] == model[word_of(14'h033C)], "R6", "inactive lane 15 held",
          64'(rsp_rdata[15*DW +: DW]), 64'(model[word_of(14'h033C)]));

    // R2: request held during a 16-pass request must be ignored
    act = '1;
    for (int l = 0; l < LANES; l++) la[l] = AW'(l * 64);
    drive(1'b0);
    req_valid = 1'b1;
    @(posedge clk); #1;
    for (int l = 0; l < LANES; l++) begin
      req_addr[l*AW +: AW]  = AW'(14'h0500);
      req_wdata[l*DW +: DW] = 32'hFACE_FACE;
    end
    req_write = 1'b1;
    while (!rsp_done) begin
      @(posedge clk); #1;
    end
    req_valid = 1'b0;
    check(rsp_passes == PW'(16), "R3", "16-way conflict", 64'(rsp_passes), 64'd16);
    for (int l = 0; l < LANES; l++) exp_rd[l] = model[word_of(la[l])];
    act = 16'h0001;
    la[0] = AW'(14'h0500);
    run(1'b0, 1, "R2");
    check(rsp_rdata[DW-1:0] == model[word_of(14'h0500)], "R2", "busy-time request dropped",
          64'(rsp_rdata[DW-1:0]), 64'(model[word_of(14'h0500)]));

    // mixed random traffic on a narrow address window
    for (int n = 0; n < 300; n++) begin
      bit wr;
      seed = nxt(seed);
      act  = seed[15:0];
      wr   = seed[20];
      for (int l = 0; l < LANES; l++) begin
        seed  = nxt(seed);
        la[l] = {6'd0, seed[1:0], seed[5:2], seed[7:6]};
        lw[l] = seed ^ 32'h5A5A_0000;
      end
      run_auto(wr, "R3");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule